// File: doc/BRIEF.md
# Masked Word-Match Trigger Unit

This block compares a word of sampled logic inputs against a pattern. Each channel has two settings. A polarity bit selects whether the channel must be high or low to count as a match. A don't-care bit takes the channel out of the comparison. The unit raises one registered hit flag when every channel that is not a don't-care has the level its polarity asks for. A capture controller can combine the hit flags of several units to form a wider trigger word.

A host loads the settings one bit at a time into a staging chain, then commits them with a load strobe. The active settings change only on that strobe, so the compare path never sees half-written settings. The same unit also contains a byte-lane selector. With it, the host can read a wide sample-memory word back through a narrow port, one byte at a time.

Top module: `trig_word_unit`

## Requirements
- R1: After reset, hit is 0 and both active setting words are all zeros. With those settings, hit rises only when every input is 1.
- R2: When cfg_step is high at a clock edge, the staging chain (2*CH_W bits) shifts toward its MSB and takes cfg_bit into bit 0. The host sends polarity bit CH_W-1 first and polarity bit 0 after it, then don't-care bit CH_W-1 first and don't-care bit 0 last. Shifting without a load has no effect on hit.
- R3: When cfg_load is high at a clock edge, the chain's upper half becomes the polarity word and its lower half becomes the don't-care word. If cfg_step is high at the same edge, the load uses the chain contents from before that shift.
- R4: A channel whose polarity bit is 0 matches when its input is 1. A channel whose polarity bit is 1 matches when its input is 0.
- R5: A channel whose don't-care bit is 1 always matches, whatever its input and polarity. If every don't-care bit is 1, hit is 1.
- R6: hit is the AND of all channel matches. It is registered, so it reflects the samp_in value present at the previous rising clock edge.
- R7: When rd_en is 1, rd_byte shows byte lane rd_sel of rd_bus, where lane 0 is bits 7:0 and lane 1 is bits 15:8. This output is combinational.
- R8: When rd_en is 0, rd_byte is all zeros whatever rd_bus and rd_sel are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; also times the configuration shifts |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bit | input | 1 | Serial setting bit |
| cfg_step | input | 1 | Shift-enable for the staging chain |
| cfg_load | input | 1 | Commits the staging chain into the active settings |
| samp_in | input | CH_W | Sampled channel inputs |
| hit | output | 1 | Registered match flag |
| rd_bus | input | RB_W | Sample-memory data word to read back |
| rd_sel | input | SEL_W | Byte lane select |
| rd_en | input | 1 | Readback enable; when low, rd_byte is zero |
| rd_byte | output | BYTE_W | Selected byte lane |

## Verification
A wrong bit in the staging chain stays hidden until the next load strobe. After that strobe, hit is wrong on the first sample that reaches the affected channel, one clock after that sample is applied. A wrong active-settings bit shows as a wrong hit one clock after any sample that exercises that channel with the other channels matching. For that reason, the stimulus keeps most samples one bit away from a full match. The readback selector holds no state, so a fault in it shows at rd_byte in the same cycle.

// File: rtl/trig_pkg.sv
package trig_pkg;

   // Number of select bits needed to address a given number of lanes.
   function automatic int sel_width(input int lanes);
      return (lanes > 1) ? $clog2(lanes) : 1;
   endfunction

endpackage

// File: rtl/trig_cfg_chain.sv
module trig_cfg_chain #(
   parameter int CH_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_bit,
   input  logic            cfg_step,
   input  logic            cfg_load,
   output logic [CH_W-1:0] pol_q,
   output logic [CH_W-1:0] dc_q
);
   localparam int CHAIN_W = 2 * CH_W;

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         pol_q   <= '0;
         dc_q    <= '0;
      end else begin
         if (cfg_step)
            chain_q <= {chain_q[CHAIN_W-2:0], cfg_bit};
         if (cfg_load) begin
            pol_q <= chain_q[CHAIN_W-1:CH_W];
            dc_q  <= chain_q[CH_W-1:0];
         end
      end
   end

   // Active settings move only on a load strobe.
   assert_hold_without_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> ($stable(pol_q) && $stable(dc_q)));

   // A shift brings the serial bit into the chain tail.
   assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_step |=> (chain_q[0] == $past(cfg_bit)));

   // A load takes the chain contents from before any shift at the same edge.
   assert_load_preshift_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> ({pol_q, dc_q} == $past(chain_q)));

endmodule

// File: rtl/trig_match.sv
module trig_match #(
   parameter int CH_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CH_W-1:0] samp_in,
   input  logic [CH_W-1:0] pol_q,
   input  logic [CH_W-1:0] dc_q,
   output logic            hit
);
   logic [CH_W-1:0] lane_ok;

   for (genvar i = 0; i < CH_W; i++) begin : g_lane
      // Polarity stage, then don't-care override.
      assign lane_ok[i] = (samp_in[i] ^ pol_q[i]) | dc_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit <= 1'b0;
      else        hit <= &lane_ok;
   end

   assert_all_dontcare_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (&dc_q) |=> hit);

   assert_polarity_lane0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!dc_q[0] && (samp_in[0] == pol_q[0])) |=> !hit);

   assert_full_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (((samp_in ^ pol_q) | dc_q) == {CH_W{1'b1}}) |=> hit);

endmodule

// File: rtl/trig_readback.sv
module trig_readback #(
   parameter int RB_W   = 16,
   parameter int BYTE_W = 8,
   parameter int SEL_W  = 1
) (
   input  logic [RB_W-1:0]   rd_bus,
   input  logic [SEL_W-1:0]  rd_sel,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_byte
);
   localparam int LANES = RB_W / BYTE_W;

   logic [BYTE_W-1:0] lane_data [LANES];

   for (genvar l = 0; l < LANES; l++) begin : g_rb_lane
      assign lane_data[l] = rd_bus[l*BYTE_W +: BYTE_W];
   end

   always_comb begin
      rd_byte = '0;
      for (int l = 0; l < LANES; l++)
         if (rd_en && (int'(rd_sel) == l)) rd_byte = lane_data[l];
   end

   always_comb begin
      if (rd_en && (rd_sel == '0))
         assert_low_lane_R7: assert (rd_byte == rd_bus[BYTE_W-1:0]);
      if (!rd_en)
         assert_quiet_when_off_R8: assert (rd_byte == '0);
   end

endmodule

// File: rtl/trig_word_unit.sv
module trig_word_unit #(
   parameter int CH_W   = 16,
   parameter int BYTE_W = 8,
   parameter int RB_W   = 16,
   localparam int LANES = RB_W / BYTE_W,
   localparam int SEL_W = trig_pkg::sel_width(RB_W / BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_bit,
   input  logic              cfg_step,
   input  logic              cfg_load,
   input  logic [CH_W-1:0]   samp_in,
   output logic              hit,
   input  logic [RB_W-1:0]   rd_bus,
   input  logic [SEL_W-1:0]  rd_sel,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_byte
);
   if (CH_W < 1) begin : g_bad_ch
      $error("CH_W must be at least 1");
   end
   if (BYTE_W < 1 || (RB_W % BYTE_W) != 0 || LANES < 1) begin : g_bad_rb
      $error("RB_W must be a nonzero multiple of BYTE_W");
   end

   logic [CH_W-1:0] pol_q;
   logic [CH_W-1:0] dc_q;

   trig_cfg_chain #(.CH_W(CH_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_bit  (cfg_bit),
      .cfg_step (cfg_step),
      .cfg_load (cfg_load),
      .pol_q    (pol_q),
      .dc_q     (dc_q)
   );

   trig_match #(.CH_W(CH_W)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .samp_in (samp_in),
      .pol_q   (pol_q),
      .dc_q    (dc_q),
      .hit     (hit)
   );

   trig_readback #(.RB_W(RB_W), .BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_rb (
      .rd_bus  (rd_bus),
      .rd_sel  (rd_sel),
      .rd_en   (rd_en),
      .rd_byte (rd_byte)
   );

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pol_q == '0 && dc_q == '0));

endmodule

// File: tb/sim_trig_word_unit.sv
module sim_trig_word_unit;
   localparam int CLK_PERIOD = 10;
   localparam int CH_W   = 16;
   localparam int BYTE_W = 8;
   localparam int RB_W   = 16;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic              rst_n;
   logic              cfg_bit, cfg_step, cfg_load;
   logic [CH_W-1:0]   samp_in;
   logic              hit;
   logic [RB_W-1:0]   rd_bus;
   logic [0:0]        rd_sel;
   logic              rd_en;
   logic [BYTE_W-1:0] rd_byte;

   trig_word_unit #(.CH_W(CH_W), .BYTE_W(BYTE_W), .RB_W(RB_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_bit(cfg_bit), .cfg_step(cfg_step),
      .cfg_load(cfg_load), .samp_in(samp_in), .hit(hit), .rd_bus(rd_bus),
      .rd_sel(rd_sel), .rd_en(rd_en), .rd_byte(rd_byte)
   );

   int n_vec = 0;
   int n_bad = 0;

   logic [2*CH_W-1:0] m_chain;
   logic [CH_W-1:0]   m_pol, m_dc;

   function automatic logic exp_hit(input logic [CH_W-1:0] s, p, d);
      return &((s ^ p) | d);
   endfunction

   function automatic logic [BYTE_W-1:0] exp_rb(input logic [RB_W-1:0] b,
                                                input logic sel, input logic en);
      if (!en) return '0;
      return sel ? b[15:8] : b[7:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Caller stands at a falling edge; one clock is consumed.
   task automatic drive_cfg(input logic st, input logic b, input logic ld);
      cfg_step = st; cfg_bit = b; cfg_load = ld;
      if (ld) begin
         m_pol = m_chain[2*CH_W-1:CH_W];
         m_dc  = m_chain[CH_W-1:0];
      end
      if (st) m_chain = {m_chain[2*CH_W-2:0], b};
      @(negedge clk);
      cfg_step = 1'b0; cfg_load = 1'b0; cfg_bit = 1'b0;
   endtask

   task automatic shift_word(input logic [CH_W-1:0] p, input logic [CH_W-1:0] d);
      logic [2*CH_W-1:0] w;
      w = {p, d};
      for (int i = 2*CH_W-1; i >= 0; i--) drive_cfg(1'b1, w[i], 1'b0);
   endtask

   task automatic apply_sample(input string req, input logic [CH_W-1:0] s);
      samp_in = s;
      @(negedge clk);
      check(req, {31'd0, hit}, {31'd0, exp_hit(s, m_pol, m_dc)});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [CH_W-1:0] s;
      void'($urandom(32'd4711));
      rst_n = 1'b0; cfg_bit = 0; cfg_step = 0; cfg_load = 0;
      samp_in = '1; rd_bus = '0; rd_sel = '0; rd_en = 0;
      m_chain = '0; m_pol = '0; m_dc = '0;
      repeat (3) @(negedge clk);
      check("R1 reset hit", {31'd0, hit}, 32'd0);
      rst_n = 1'b1;

      // R1: zero settings need all ones
      apply_sample("R1 all-ones", 16'hFFFF);
      apply_sample("R1 one low", 16'hFFDF);

      // R4 polarity
      shift_word(16'h00FF, 16'h0000);
      drive_cfg(1'b0, 1'b0, 1'b1);
      apply_sample("R4 inverted match", 16'hFF00);
      apply_sample("R4 inverted mismatch", 16'hFF01);
      apply_sample("R4 high lane mismatch", 16'h7F00);

      // R5 don't-care
      shift_word(16'h0000, 16'h0F0F);
      drive_cfg(1'b0, 1'b0, 1'b1);
      apply_sample("R5 masked lanes ignored", 16'hF0F0);
      apply_sample("R5 unmasked lane low", 16'hE0F0);
      shift_word(16'h1234, 16'hFFFF);
      drive_cfg(1'b0, 1'b0, 1'b1);
      for (int i = 0; i < 4; i++) apply_sample("R5 all dont-care", 16'($urandom));

      // R2: shifting without load leaves matching untouched
      shift_word(16'hAAAA, 16'h0000);
      apply_sample("R2 old settings kept", 16'h0000);
      apply_sample("R2 old settings kept b", 16'h5555);
      drive_cfg(1'b0, 1'b0, 1'b1);
      apply_sample("R2 new settings after load", 16'h5555);
      apply_sample("R2 new settings mismatch", 16'h5554);

      // R3: load with simultaneous shift uses pre-shift chain
      shift_word(16'h0F00, 16'h0003);
      drive_cfg(1'b1, 1'b1, 1'b1);
      apply_sample("R3 load/shift same edge", 16'hF0FC);
      apply_sample("R3 load/shift mismatch", 16'hF0F8);

      // R6 random vectors near a full match
      for (int v = 0; v < 400; v++) begin
         if (v % 40 == 0) begin
            shift_word(16'($urandom), 16'($urandom) & 16'($urandom) & 16'($urandom));
            drive_cfg(1'b0, 1'b0, 1'b1);
         end
         s = ~m_pol;
         if ($urandom % 3 != 0) s = s ^ (16'd1 << ($urandom % CH_W));
         apply_sample("R6 random", s);
      end

      // R7/R8 readback
      for (int v = 0; v < 60; v++) begin
         rd_bus = 16'($urandom);
         rd_sel = 1'($urandom);
         rd_en  = (v % 4 != 0);
         #1;
         if (rd_en) check("R7 lane select", {24'd0, rd_byte}, {24'd0, exp_rb(rd_bus, rd_sel[0], rd_en)});
         else       check("R8 disabled zero", {24'd0, rd_byte}, 32'd0);
         @(negedge clk);
      end
      rd_bus = 16'hBEEF; rd_en = 1; rd_sel = 0; #1;
      check("R7 low byte", {24'd0, rd_byte}, 32'hEF);
      rd_sel = 1; #1;
      check("R7 high byte", {24'd0, rd_byte}, 32'hBE);
      rd_en = 0; #1;
      check("R8 off high sel", {24'd0, rd_byte}, 32'd0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule